// File: doc/BRIEF.md
# Dual-Mode Watchdog and Interval Timer

This peripheral timer has one 8-bit up-counter that advances on a count clock taken from a selectable prescaler of the peripheral clock. A single control/status register picks what happens when the counter wraps. In watchdog mode, the wrap sets a watchdog flag and sends out a reset pulse. That pulse drives the active-low reset pin low and both status pins high. Its length depends on the reset type selected. In interval mode, the wrap sets an interval flag that holds an interrupt request up until software clears it.

Software loads a start value into the counter, sets the mode, reset type, clock selection and enable bit, and then leaves the timer running. In watchdog mode, software writes zero to the counter from time to time so that the counter never wraps. The counter keeps running after every wrap in both modes.

A simple register bus has a write strobe, a one-bit write address, a one-bit read address and a combinational read port. Address 0 selects the control/status register and address 1 selects the counter.

Top module: `wdog_timer`

## Requirements
- R1: Control bit 7 selects the mode. A value of 1 is watchdog mode and a value of 0 is interval mode. The mode held before a wrap decides which flag the wrap sets and whether a reset pulse follows.
- R2: Address 0 reads back the control register as {mode[7], reset type[6], enable[5], watchdog flag[4], interval flag[3], clock select[2:0]}. Address 1 reads and writes the counter.
- R3: Clock-select codes 0 to 7 give count-clock ratios of 2, 4, 8, 16, 32, 64, 256 and 1024 peripheral-clock cycles per count.
- R4: With enable bit 5 at 0, the counter holds its value and the prescaler restarts from zero.
- R5: The counter wraps from 0xFF to 0x00 on a count. That wrap is the overflow, and counting goes on after it.
- R6: A counter write in the same cycle as a count takes priority: the written value is loaded and no overflow occurs.
- R7: A watchdog-mode overflow sets flag bit 4. While the reset pulse lasts, rst_out_n is 0 and stat_out is 2'b11; otherwise rst_out_n is 1 and stat_out is 2'b00.
- R8: With bit 6 = 0 (power-on type), the pulse lasts one count-clock period, which is the selected ratio in cycles. With bit 6 = 1 (manual type), it lasts 5 cycles.
- R9: An interval-mode overflow sets flag bit 3, and irq equals that flag.
- R10: Writing 0 to a flag bit clears it, and writing 1 leaves it unchanged. An overflow in the same cycle as a clearing write leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | Write address (0 control, 1 counter) |
| wr_data | input | 8 | Write data |
| rd_addr | input | 1 | Read address (0 control, 1 counter) |
| rd_data | output | 8 | Read data |
| rst_out_n | output | 1 | Reset output, low while the pulse is active |
| stat_out | output | 2 | Status pins, both high while the pulse is active |
| irq | output | 1 | Interval interrupt request |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is a software counter write and the count that would wrap the counter. The second pair is a flag-clearing control write and an overflow. The bench's reference model tells it exactly which cycle will carry a wrapping count. The bench places the write in that cycle. It then judges the result through the read port and the irq pin: after a counter write, no flag may be set; after a clearing write, the flag must still be set.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
    localparam int CNT_W      = 8;
    localparam int PRE_W      = 10;
    localparam int PULSE_W    = PRE_W + 1;
    localparam int MANUAL_CYC = 5;
    localparam int SEL_W      = 3;

    typedef struct packed {
        logic             mode;        // 1 watchdog, 0 interval
        logic             rst_manual;  // 1 manual, 0 power-on
        logic             enable;
        logic             wflag;
        logic             iflag;
        logic [SEL_W-1:0] clk_sel;
    } ctrl_t;

    function automatic logic [3:0] div_shift(input logic [SEL_W-1:0] sel);
        logic [3:0] s;
        case (sel)
            3'd0: s = 4'd1;
            3'd1: s = 4'd2;
            3'd2: s = 4'd3;
            3'd3: s = 4'd4;
            3'd4: s = 4'd5;
            3'd5: s = 4'd6;
            3'd6: s = 4'd8;
            default: s = 4'd10;
        endcase
        return s;
    endfunction

    function automatic logic [PRE_W-1:0] div_mask(input logic [SEL_W-1:0] sel);
        logic [PRE_W:0] one_hot;
        one_hot = (PRE_W+1)'(1) << div_shift(sel);
        return PRE_W'(one_hot - 1'b1);
    endfunction
endpackage

// File: rtl/wdog_prescale.sv
module wdog_prescale
    import wdog_pkg::*;
#(
    parameter int W = PRE_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [SEL_W-1:0] clk_sel,
    output logic             tick
);
    logic [W-1:0] pre_q;
    logic [W-1:0] mask;

    assign mask = W'(div_mask(clk_sel));
    assign tick = run && ((pre_q & mask) == mask);

    always_ff @(posedge clk) begin
        if (rst || !run) pre_q <= '0;
        else             pre_q <= pre_q + 1'b1;
    end
endmodule

// File: rtl/wdog_count.sv
module wdog_count #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] count,
    output logic         wrap
);
    assign wrap = tick && !load && (count == {W{1'b1}});

    always_ff @(posedge clk) begin
        if (rst)       count <= '0;
        else if (load) count <= load_val;
        else if (tick) count <= count + 1'b1;
    end
endmodule

// File: rtl/wdog_pulse.sv
module wdog_pulse
    import wdog_pkg::*;
#(
    parameter int W      = PULSE_W,
    parameter int MANUAL = MANUAL_CYC
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fire,
    input  logic             manual,
    input  logic [SEL_W-1:0] clk_sel,
    output logic             active
);
    logic [W-1:0] rem_q;
    logic [W-1:0] len;

    assign len    = manual ? W'(MANUAL) : (W'(1) << div_shift(clk_sel));
    assign active = (rem_q != '0);

    always_ff @(posedge clk) begin
        if (rst)         rem_q <= '0;
        else if (fire)   rem_q <= len;
        else if (active) rem_q <= rem_q - 1'b1;
    end
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
    import wdog_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic       wr_addr,
    input  logic [7:0] wr_data,
    input  logic       rd_addr,
    output logic [7:0] rd_data,
    output logic       rst_out_n,
    output logic [1:0] stat_out,
    output logic       irq
);
    ctrl_t             ctrl_q, ctrl_d, wr_ctrl;
    logic              tick, wrap, cnt_wr, ctrl_wr, pulse_on;
    logic [CNT_W-1:0]  count;

    assign cnt_wr  = wr_en &&  wr_addr;
    assign ctrl_wr = wr_en && !wr_addr;
    assign wr_ctrl = ctrl_t'(wr_data);

    wdog_prescale #(.W(PRE_W)) u_pre (
        .clk(clk), .rst(rst), .run(ctrl_q.enable),
        .clk_sel(ctrl_q.clk_sel), .tick(tick)
    );

    wdog_count #(.W(CNT_W)) u_cnt (
        .clk(clk), .rst(rst), .tick(tick), .load(cnt_wr),
        .load_val(wr_data[CNT_W-1:0]), .count(count), .wrap(wrap)
    );

    wdog_pulse #(.W(PULSE_W), .MANUAL(MANUAL_CYC)) u_pulse (
        .clk(clk), .rst(rst), .fire(wrap && ctrl_q.mode),
        .manual(ctrl_q.rst_manual), .clk_sel(ctrl_q.clk_sel),
        .active(pulse_on)
    );

    always_comb begin
        ctrl_d = ctrl_q;
        if (ctrl_wr) begin
            ctrl_d.mode       = wr_ctrl.mode;
            ctrl_d.rst_manual = wr_ctrl.rst_manual;
            ctrl_d.enable     = wr_ctrl.enable;
            ctrl_d.clk_sel    = wr_ctrl.clk_sel;
            ctrl_d.wflag      = ctrl_q.wflag & wr_ctrl.wflag;
            ctrl_d.iflag      = ctrl_q.iflag & wr_ctrl.iflag;
        end
        if (wrap) begin
            if (ctrl_q.mode) ctrl_d.wflag = 1'b1;
            else             ctrl_d.iflag = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) ctrl_q <= '0;
        else     ctrl_q <= ctrl_d;
    end

    assign rd_data   = rd_addr ? 8'(count) : 8'(ctrl_q);
    assign rst_out_n = !pulse_on;
    assign stat_out  = {2{pulse_on}};
    assign irq       = ctrl_q.iflag;
endmodule

// File: rtl/wdog_timer_chk.sv
module wdog_timer_chk (
    input logic       clk,
    input logic       rst,
    input logic       rst_out_n,
    input logic [1:0] stat_out,
    input logic       irq,
    input logic       mode,
    input logic       enable,
    input logic       cnt_wr,
    input logic [7:0] count,
    input logic       wrap,
    input logic       wflag
);
    // R7
    status_pins_chk: assert property (@(posedge clk) disable iff (rst)
        !rst_out_n |-> (stat_out == 2'b11));
    // R7
    pulse_flag_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst_out_n) |-> wflag);
    // R9
    irq_mode_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> !$past(mode));
    // R4
    hold_count_chk: assert property (@(posedge clk) disable iff (rst)
        (!enable && !cnt_wr) |=> $stable(count));
    // R10
    wflag_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(wflag) |-> $past(wrap));
    // R5
    wrap_value_chk: assert property (@(posedge clk) disable iff (rst)
        wrap |=> (count == 8'h00));
endmodule

bind wdog_timer wdog_timer_chk u_chk (
    .clk(clk), .rst(rst), .rst_out_n(rst_out_n), .stat_out(stat_out),
    .irq(irq), .mode(ctrl_q.mode), .enable(ctrl_q.enable),
    .cnt_wr(cnt_wr), .count(count), .wrap(wrap), .wflag(ctrl_q.wflag)
);

// File: tb/wdog_timer_test.sv
`timescale 1ns/1ps
module wdog_timer_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0, wr_addr = 1'b0, rd_addr = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       rst_out_n, irq;
    logic [1:0] stat_out;

    int checks = 0, errors = 0, low_seen = 0;
    int m_pre = 0, m_cnt = 0, m_rem = 0;
    logic [7:0] m_ctrl = 8'h00;

    always #2 clk = ~clk;

    wdog_timer uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .rst_out_n(rst_out_n), .stat_out(stat_out), .irq(irq)
    );

    function automatic int ratio(input logic [2:0] s);
        int t[8] = '{2, 4, 8, 16, 32, 64, 256, 1024};
        return t[s];
    endfunction

    function automatic bit tick_next();
        int d = ratio(m_ctrl[2:0]);
        return m_ctrl[5] && ((m_pre % d) == d - 1);
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // reference model, one step per clock
    always @(posedge clk) begin
        if (rst) begin
            m_pre = 0; m_cnt = 0; m_rem = 0; m_ctrl = 8'h00;
        end else begin
            int d;
            bit tk, cw, ov;
            logic [7:0] nc;
            d  = ratio(m_ctrl[2:0]);
            tk = tick_next();
            cw = wr_en && wr_addr;
            ov = tk && !cw && (m_cnt == 255);
            if (ov && m_ctrl[7]) m_rem = m_ctrl[6] ? 5 : d;
            else if (m_rem > 0) m_rem = m_rem - 1;
            m_pre = m_ctrl[5] ? (m_pre + 1) % 1024 : 0;
            if (cw) m_cnt = wr_data;
            else if (tk) m_cnt = (m_cnt + 1) % 256;
            nc = m_ctrl;
            if (wr_en && !wr_addr)
                nc = {wr_data[7:5], m_ctrl[4:3] & wr_data[4:3], wr_data[2:0]};
            if (ov) begin
                if (m_ctrl[7]) nc[4] = 1'b1;
                else           nc[3] = 1'b1;
            end
            m_ctrl = nc;
        end
    end

    // per-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (!rst) begin
            check(rst_out_n == (m_rem == 0), "R7/R8 rst_out_n", rst_out_n, m_rem == 0);
            check(stat_out == ((m_rem != 0) ? 2'b11 : 2'b00), "R7 stat_out", stat_out, (m_rem != 0) ? 3 : 0);
            check(irq == m_ctrl[3], "R9 irq", irq, m_ctrl[3]);
            check(rd_data == (rd_addr ? 8'(m_cnt) : m_ctrl), "R2 rd_data", rd_data,
                  rd_addr ? m_cnt : int'(m_ctrl));
        end
        if (!rst && !rst_out_n) low_seen++;
    end

    task automatic wr(input logic a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic rd(input logic a, output logic [7:0] v);
        rd_addr = a;
        @(negedge clk);
        v = rd_data;
    endtask

    task automatic wait_wrap_tick();
        int guard = 0;
        @(negedge clk);
        while (!(tick_next() && m_cnt == 255) && guard < 5000) begin
            @(negedge clk);
            guard++;
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(4 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [7:0] v;
        int l0;
        idle(3);
        rst = 1'b0;
        #1;
        // reset state (R2)
        rd(1'b0, v); check(v == 8'h00, "R2 reset ctrl", v, 0);
        rd(1'b1, v); check(v == 8'h00, "R2 reset counter", v, 0);
        check(rst_out_n && stat_out == 2'b00 && !irq, "R7 reset pins", {rst_out_n, stat_out, irq}, 8);

        // R4: disabled counter holds
        wr(1'b1, 8'h33); idle(50);
        rd(1'b1, v); check(v == 8'h33, "R4 hold when disabled", v, 8'h33);

        // R9, R5: interval overflow, ratio 2
        wr(1'b1, 8'hFF); wr(1'b0, 8'b0010_0000); idle(6);
        rd(1'b0, v); check(v[3] == 1'b1 && irq, "R9 interval flag", v, 8'h28);
        check(v[4] == 1'b0, "R1 no watchdog flag in interval mode", v[4], 0);
        rd(1'b1, v); check(v < 8'h05, "R5 wrapped and counting", v, 2);
        // R10: write 1 keeps, write 0 clears
        wr(1'b0, 8'b0011_1000); rd(1'b0, v); check(v[3] == 1'b1, "R10 write one no effect", v[3], 1);
        wr(1'b0, 8'b0010_0000); rd(1'b0, v); check(v[3] == 1'b0 && !irq, "R10 write zero clears", v[3], 0);

        // R10: clear collides with overflow
        wr(1'b1, 8'hF0); wait_wrap_tick(); wr(1'b0, 8'b0010_0000);
        rd(1'b0, v); check(v[3] == 1'b1, "R10 overflow beats clear", v[3], 1);
        wr(1'b0, 8'b0010_0000);

        // R6: counter write collides with wrapping count
        wr(1'b1, 8'hF8); wait_wrap_tick(); wr(1'b1, 8'h10);
        rd(1'b0, v); check(v[3] == 1'b0 && !irq, "R6 write suppresses overflow", v[3], 0);
        wr(1'b0, 8'h00);

        // R3: ratio 1024 takes two counts from 0xFE
        wr(1'b1, 8'hFE); wr(1'b0, 8'b0010_0111); idle(1900);
        rd(1'b0, v); check(v[3] == 1'b0, "R3 ratio 1024 early", v[3], 0);
        idle(250);
        rd(1'b0, v); check(v[3] == 1'b1, "R3 ratio 1024 overflow", v[3], 1);
        wr(1'b0, 8'h00);

        // R8: manual reset pulse of 5 cycles, ratio 2
        l0 = low_seen;
        wr(1'b1, 8'hFE); wr(1'b0, 8'b1110_0000); idle(40);
        check(low_seen - l0 == 5, "R8 manual pulse length", low_seen - l0, 5);
        rd(1'b0, v); check(v[4] == 1'b1 && v[3] == 1'b0, "R7 watchdog flag", v, 8'hF0);
        check(!irq, "R1 no irq in watchdog mode", irq, 0);
        wr(1'b0, 8'h00);

        // R8: power-on pulse lasts one count period, ratio 16
        l0 = low_seen;
        wr(1'b1, 8'hFE); wr(1'b0, 8'b1010_0011); idle(80);
        check(low_seen - l0 == 16, "R8 power-on pulse length", low_seen - l0, 16);
        wr(1'b0, 8'h00);

        // R1/R6: periodic zero writes keep the watchdog quiet
        l0 = low_seen;
        wr(1'b1, 8'h00); wr(1'b0, 8'b1110_0000);
        for (int i = 0; i < 20; i++) begin
            idle(300);
            wr(1'b1, 8'h00);
        end
        check(low_seen == l0, "R1 kicked watchdog never resets", low_seen - l0, 0);
        rd(1'b0, v); check(v[4] == 1'b0, "R1 kicked watchdog flag clear", v[4], 0);
        wr(1'b0, 8'h00);
        idle(5);
        finish_run();
    end
endmodule